// File: doc/BRIEF.md
# LIN-Ready Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. Its transmitter and receiver run at the same time and independently of each other, and each carries 8-bit frames on its own line. On top of plain byte transfer it supports three functions that single-wire bus networks need. It can send a long break of twelve low bit times. It can stay armed while idle and report a wake event when the line is pulled low. It can measure the bit rate of an incoming sync byte and load the matching divisor by itself.

Both directions share one oversampling tick. A divisor value N makes the tick period N+1 clock cycles, and one bit lasts 16 ticks. Software controls the block through strobes and flags grouped by direction: a transmit group, a receive group, and a baud group that holds the divisor and the calibration controls. When the port enable is low, the transmit output is released and the receiver is held idle.

Top module: `lin_uart`

## Requirements
- R1: A transmit frame is one low start bit, the 8 data bits with the LSB first, and one high stop bit. The frame begins on an oversample tick and each bit lasts 16 ticks of N+1 clocks. A write that arrives while a frame is pending or in progress is dropped.
- R2: The receiver starts on a falling edge of the line. It samples each bit at ticks 7, 8 and 9 of that bit and takes the majority vote. After the stop bit it raises rx_valid with the byte, and a pulse on rx_rd clears rx_valid.
- R3: Transmission and reception can overlap in time without corrupting each other.
- R4: A write with tx_brk set sends 12 bit times of low line and then one high stop bit, and no data frame.
- R5: A stop bit that votes low stores the byte with ferr set. A stop bit that votes high stores the byte with ferr clear.
- R6: A byte that completes while rx_valid is still set is dropped and sets the sticky oerr flag. The unread byte is kept.
- R7: A pulse on wake_arm sets wake_armed and clears wake_flag. While armed, a falling edge on the line sets wake_flag and the rising edge that follows clears wake_armed. No byte is stored for the break.
- R8: A pulse on abd_arm arms calibration, which expects the byte 0x55. The block counts clocks from the first falling edge to the fifth one (8 bit times). It loads div_q = count/128 − 1, clears abd_armed, and stores no byte.
- R9: If the calibration counter reaches its limit before the fifth falling edge, abd_ovf is set, abd_armed clears and div_q keeps its value.
- R10: While port_en is low, tx_o is high and tx_oe is low, transmit writes and received frames are ignored, and rx_valid, ferr and oerr are cleared. While port_en is high, tx_oe is high.
- R11: A low pulse on the line that has returned high before sample tick 7 of the start bit is rejected, and no byte is stored.
- R12: A pulse on div_wr loads div_wdata into div_q, and the bit timing of both directions follows the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | DIV_W | Divisor write value |
| div_q | output | DIV_W | Current divisor (tick period minus one) |
| tx_wr | input | 1 | Start transmission strobe |
| tx_data | input | 8 | Byte to send |
| tx_brk | input | 1 | With tx_wr: send a break instead of tx_data |
| tx_busy | output | 1 | Transmit request pending or in progress |
| tx_o | output | 1 | Serial transmit line |
| tx_oe | output | 1 | Transmit pin output enable |
| rx_i | input | 1 | Serial receive line |
| rx_rd | input | 1 | Read strobe, clears rx_valid |
| rx_data | output | 8 | Last stored byte |
| rx_valid | output | 1 | Unread byte present |
| ferr | output | 1 | Stop bit of the stored byte was low |
| oerr | output | 1 | A byte was lost to overrun (sticky) |
| wake_arm | input | 1 | Arm wake detection |
| wake_armed | output | 1 | Wake detection active |
| wake_flag | output | 1 | Wake break seen |
| abd_arm | input | 1 | Arm bit-rate calibration |
| abd_armed | output | 1 | Calibration active |
| abd_ovf | output | 1 | Calibration counter overflowed |

## Verification
Every byte value goes out on the transmit line while a different byte, the same value XOR 0x3C, comes in on the receive line at the same time. This sweep separates bit-order and bit-length faults from faults where the two directions interfere. A break, a frame with a low stop bit, two unread frames in a row and a short glitch each exercise one receiver or transmitter corner that the plain frames cannot reach. Sync bytes sent at two different bit rates show whether calibration scales the count or only detects the edges. A line held low past the counter limit, followed by a frame at a newly written divisor, separates the overflow path from a real divisor load.

// File: rtl/lin_uart_pkg.sv
package lin_uart_pkg;
    typedef enum logic [1:0] {
        CAL_OFF  = 2'd0,
        CAL_WAIT = 2'd1,
        CAL_RUN  = 2'd2
    } cal_phase_e;

    typedef enum logic {
        RXP_IDLE = 1'b0,
        RXP_BUSY = 1'b1
    } rx_phase_e;

    localparam int FRAME_BITS = 10;
    localparam int BREAK_BITS = 13;
    localparam int SHIFT_W    = 13;
endpackage

// File: rtl/lin_uart_baud.sv
module lin_uart_baud #(
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr,
    input  logic [DIV_W-1:0] sw_val,
    input  logic             cal_wr,
    input  logic [DIV_W-1:0] cal_val,
    output logic [DIV_W-1:0] div_o,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } baud_st_t;

    baud_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = (st_q.cnt >= st_q.div);
        if (tick_o) st_d.cnt = '0;
        else        st_d.cnt = st_q.cnt + DIV_W'(1);
        if (cal_wr)     st_d.div = cal_val;
        else if (sw_wr) st_d.div = sw_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.div <= DIV_W'(DIV_RESET);
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o = st_q.div;
endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx
    import lin_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       wr,
    input  logic       brk,
    input  logic [7:0] data,
    output logic       line_o,
    output logic       busy_o
);
    typedef struct packed {
        logic               pend;
        logic               pend_brk;
        logic [7:0]         pend_data;
        logic               busy;
        logic [SHIFT_W-1:0] sh;
        logic [3:0]         nbits;
        logic [3:0]         tcnt;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.pend = 1'b0;
            st_d.busy = 1'b0;
        end else begin
            if (wr && !st_q.busy && !st_q.pend) begin
                st_d.pend      = 1'b1;
                st_d.pend_brk  = brk;
                st_d.pend_data = data;
            end
            if (st_q.pend && tick) begin
                st_d.pend = 1'b0;
                st_d.busy = 1'b1;
                st_d.tcnt = 4'd0;
                if (st_q.pend_brk) begin
                    st_d.sh    = {1'b1, {(SHIFT_W-1){1'b0}}};
                    st_d.nbits = 4'(BREAK_BITS);
                end else begin
                    st_d.sh    = {{(SHIFT_W-FRAME_BITS){1'b1}}, 1'b1, st_q.pend_data, 1'b0};
                    st_d.nbits = 4'(FRAME_BITS);
                end
            end else if (st_q.busy && tick) begin
                if (st_q.tcnt == 4'd15) begin
                    st_d.tcnt = 4'd0;
                    if (st_q.nbits == 4'd1) begin
                        st_d.busy = 1'b0;
                    end else begin
                        st_d.sh    = {1'b1, st_q.sh[SHIFT_W-1:1]};
                        st_d.nbits = st_q.nbits - 4'd1;
                    end
                end else begin
                    st_d.tcnt = st_q.tcnt + 4'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend      <= 1'b0;
            st_q.pend_brk  <= 1'b0;
            st_q.pend_data <= '0;
            st_q.busy      <= 1'b0;
            st_q.sh        <= '1;
            st_q.nbits     <= '0;
            st_q.tcnt      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.busy ? st_q.sh[0] : 1'b1;
    assign busy_o = st_q.busy | st_q.pend;
endmodule

// File: rtl/lin_uart_rx.sv
module lin_uart_rx
    import lin_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       clr,
    input  logic       tick,
    input  logic       line_i,
    input  logic       rd,
    output logic       fall_o,
    output logic       rise_o,
    output logic [7:0] data_o,
    output logic       valid_o,
    output logic       ferr_o,
    output logic       oerr_o
);
    typedef struct packed {
        logic [2:0] syn;
        rx_phase_e  phase;
        logic [3:0] scnt;
        logic [3:0] bitn;
        logic [1:0] smp;
        logic [7:0] sh;
        logic [7:0] data;
        logic       valid;
        logic       ferr;
        logic       oerr;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   cur, vote;

    assign cur    = st_q.syn[1];
    assign fall_o = st_q.syn[2] & ~st_q.syn[1];
    assign rise_o = ~st_q.syn[2] & st_q.syn[1];
    assign vote   = (st_q.smp[0] & st_q.smp[1]) | (st_q.smp[0] & cur) | (st_q.smp[1] & cur);

    always_comb begin
        st_d     = st_q;
        st_d.syn = {st_q.syn[1:0], line_i};
        if (rd) st_d.valid = 1'b0;
        if (clr) begin
            st_d.valid = 1'b0;
            st_d.ferr  = 1'b0;
            st_d.oerr  = 1'b0;
            st_d.phase = RXP_IDLE;
        end else if (!en) begin
            st_d.phase = RXP_IDLE;
        end else if (st_q.phase == RXP_IDLE) begin
            if (fall_o) begin
                st_d.phase = RXP_BUSY;
                st_d.scnt  = 4'd0;
                st_d.bitn  = 4'd0;
            end
        end else if (tick) begin
            st_d.scnt = st_q.scnt + 4'd1;
            if (st_q.scnt == 4'd6) st_d.smp[0] = cur;
            if (st_q.scnt == 4'd7) st_d.smp[1] = cur;
            if (st_q.scnt == 4'd8) begin
                st_d.bitn = st_q.bitn + 4'd1;
                if (st_q.bitn == 4'd0) begin
                    if (vote) st_d.phase = RXP_IDLE;
                end else if (st_q.bitn <= 4'd8) begin
                    st_d.sh = {vote, st_q.sh[7:1]};
                end else begin
                    st_d.phase = RXP_IDLE;
                    if (st_q.valid && !rd) begin
                        st_d.oerr = 1'b1;
                    end else begin
                        st_d.data  = st_q.sh;
                        st_d.valid = 1'b1;
                        st_d.ferr  = ~vote;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.syn   <= 3'b111;
            st_q.phase <= RXP_IDLE;
            st_q.scnt  <= '0;
            st_q.bitn  <= '0;
            st_q.smp   <= '0;
            st_q.sh    <= '0;
            st_q.data  <= '0;
            st_q.valid <= 1'b0;
            st_q.ferr  <= 1'b0;
            st_q.oerr  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;
    assign ferr_o  = st_q.ferr;
    assign oerr_o  = st_q.oerr;
endmodule

// File: rtl/lin_uart_watch.sv
module lin_uart_watch
    import lin_uart_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int ABD_W    = 16,
    parameter int PRE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fall,
    input  logic             rise,
    input  logic             wake_arm,
    input  logic             abd_arm,
    output logic             wake_on_o,
    output logic             wake_hit_o,
    output logic             cal_on_o,
    output logic             cal_ovf_o,
    output logic             cal_wr_o,
    output logic [DIV_W-1:0] cal_val_o
);
    localparam int PRE_W              = (PRE_LOG2 > 0) ? PRE_LOG2 : 1;
    localparam int SHIFT              = 7 - PRE_LOG2;
    localparam logic [PRE_W-1:0] PMAX = PRE_W'((1 << PRE_LOG2) - 1);
    localparam logic [ABD_W-1:0] CINIT = (PRE_LOG2 == 0) ? ABD_W'(1) : ABD_W'(0);

    typedef struct packed {
        logic             wake_on;
        logic             wake_hit;
        cal_phase_e       phase;
        logic             ovf;
        logic [PRE_W-1:0] pre;
        logic [ABD_W-1:0] cnt;
        logic [2:0]       edges;
    } watch_st_t;

    watch_st_t        st_d, st_q;
    logic             inc;
    logic [ABD_W-1:0] meas, meas_m1;

    assign inc     = (st_q.pre == PMAX);
    assign meas    = st_q.cnt >> SHIFT;
    assign meas_m1 = (meas == '0) ? '0 : meas - ABD_W'(1);
    assign cal_val_o = DIV_W'(meas_m1);

    always_comb begin
        st_d     = st_q;
        cal_wr_o = 1'b0;
        if (!en) begin
            st_d.wake_on  = 1'b0;
            st_d.wake_hit = 1'b0;
            st_d.phase    = CAL_OFF;
            st_d.ovf      = 1'b0;
        end else begin
            if (wake_arm) begin
                st_d.wake_on  = 1'b1;
                st_d.wake_hit = 1'b0;
            end else if (st_q.wake_on) begin
                if (fall) st_d.wake_hit = 1'b1;
                if (rise && st_q.wake_hit) st_d.wake_on = 1'b0;
            end
            if (abd_arm) begin
                st_d.phase = CAL_WAIT;
                st_d.ovf   = 1'b0;
            end else if (st_q.phase == CAL_WAIT) begin
                if (fall) begin
                    st_d.phase = CAL_RUN;
                    st_d.cnt   = CINIT;
                    st_d.pre   = '0;
                    st_d.edges = 3'd1;
                end
            end else if (st_q.phase == CAL_RUN) begin
                if (fall && st_q.edges == 3'd4) begin
                    cal_wr_o   = 1'b1;
                    st_d.phase = CAL_OFF;
                end else begin
                    if (fall) st_d.edges = st_q.edges + 3'd1;
                    st_d.pre = inc ? '0 : st_q.pre + PRE_W'(1);
                    if (inc) begin
                        if (st_q.cnt == '1) begin
                            st_d.ovf   = 1'b1;
                            st_d.phase = CAL_OFF;
                        end else begin
                            st_d.cnt = st_q.cnt + ABD_W'(1);
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wake_on  <= 1'b0;
            st_q.wake_hit <= 1'b0;
            st_q.phase    <= CAL_OFF;
            st_q.ovf      <= 1'b0;
            st_q.pre      <= '0;
            st_q.cnt      <= '0;
            st_q.edges    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wake_on_o  = st_q.wake_on;
    assign wake_hit_o = st_q.wake_hit;
    assign cal_on_o   = (st_q.phase != CAL_OFF);
    assign cal_ovf_o  = st_q.ovf;
endmodule

// File: rtl/lin_uart.sv
module lin_uart #(
    parameter int DIV_W        = 16,
    parameter int DIV_RESET    = 15,
    parameter int ABD_W        = 16,
    parameter int ABD_PRE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    output logic [DIV_W-1:0] div_q,
    input  logic             tx_wr,
    input  logic [7:0]       tx_data,
    input  logic             tx_brk,
    output logic             tx_busy,
    output logic             tx_o,
    output logic             tx_oe,
    input  logic             rx_i,
    input  logic             rx_rd,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             ferr,
    output logic             oerr,
    input  logic             wake_arm,
    output logic             wake_armed,
    output logic             wake_flag,
    input  logic             abd_arm,
    output logic             abd_armed,
    output logic             abd_ovf
);
    logic             tick, fall, rise, cal_wr, rx_en;
    logic [DIV_W-1:0] cal_val;

    assign tx_oe = port_en;
    assign rx_en = port_en & ~wake_armed & ~abd_armed;

    lin_uart_baud #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) i_baud (
        .clk(clk), .rst_n(rst_n),
        .sw_wr(div_wr), .sw_val(div_wdata),
        .cal_wr(cal_wr), .cal_val(cal_val),
        .div_o(div_q), .tick_o(tick)
    );

    lin_uart_tx i_tx (
        .clk(clk), .rst_n(rst_n), .en(port_en), .tick(tick),
        .wr(tx_wr), .brk(tx_brk), .data(tx_data),
        .line_o(tx_o), .busy_o(tx_busy)
    );

    lin_uart_rx i_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .clr(~port_en), .tick(tick),
        .line_i(rx_i), .rd(rx_rd),
        .fall_o(fall), .rise_o(rise),
        .data_o(rx_data), .valid_o(rx_valid), .ferr_o(ferr), .oerr_o(oerr)
    );

    lin_uart_watch #(.DIV_W(DIV_W), .ABD_W(ABD_W), .PRE_LOG2(ABD_PRE_LOG2)) i_watch (
        .clk(clk), .rst_n(rst_n), .en(port_en),
        .fall(fall), .rise(rise),
        .wake_arm(wake_arm), .abd_arm(abd_arm),
        .wake_on_o(wake_armed), .wake_hit_o(wake_flag),
        .cal_on_o(abd_armed), .cal_ovf_o(abd_ovf),
        .cal_wr_o(cal_wr), .cal_val_o(cal_val)
    );
endmodule

// File: rtl/lin_uart_chk.sv
module lin_uart_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_en,
    input logic [DIV_W-1:0] div_q,
    input logic             tx_busy,
    input logic             tx_o,
    input logic [7:0]       rx_data,
    input logic             rx_valid,
    input logic             oerr,
    input logic             wake_armed,
    input logic             wake_flag,
    input logic             abd_armed,
    input logic             abd_ovf
);
    // R10
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!tx_busy && !rx_valid && !oerr));

    // R1
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_o) |-> tx_busy);

    // R9
    ovf_keeps_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abd_ovf) |-> ($stable(div_q) && !abd_armed));

    // R6
    overrun_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oerr) |-> (rx_valid && $stable(rx_data)));

    // R7
    wake_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wake_armed) && port_en) |-> wake_flag);

    // R8
    no_store_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> (!$past(wake_armed) && !$past(abd_armed)));
endmodule

bind lin_uart lin_uart_chk #(.DIV_W(DIV_W)) i_chk (.*);

// File: tb/test_lin_uart.sv
module test_lin_uart;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic        div_wr = 1'b0;
    logic [15:0] div_wdata = '0;
    logic [15:0] div_q;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_brk = 1'b0;
    logic        tx_busy, tx_o, tx_oe;
    logic        rx_i = 1'b1;
    logic        rx_rd = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_valid, ferr, oerr;
    logic        wake_arm = 1'b0;
    logic        wake_armed, wake_flag;
    logic        abd_arm = 1'b0;
    logic        abd_armed, abd_ovf;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    lin_uart #(.DIV_W(16), .DIV_RESET(0), .ABD_W(16), .ABD_PRE_LOG2(0)) i_lin_uart (.*);

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b, input int p, input logic stopv);
        int bt = 16 * p;
        rx_i = 1'b0;
        wait_clk(bt);
        for (int i = 0; i < 8; i++) begin
            rx_i = b[i];
            wait_clk(bt);
        end
        rx_i = stopv;
        wait_clk(bt);
        rx_i = 1'b1;
    endtask

    task automatic tx_expect(input logic [7:0] b, input int p, input string req);
        logic [9:0] got = '0;
        int         lim = 0;
        tx_data = b;
        tx_brk  = 1'b0;
        pulse(tx_wr);
        while (tx_o && lim < 200) begin
            @(negedge clk);
            lim++;
        end
        wait_clk(8 * p);
        for (int i = 0; i < 10; i++) begin
            got[i] = tx_o;
            if (i < 9) wait_clk(16 * p);
        end
        check(got == {1'b1, b, 1'b0}, req, "tx frame", int'(got), int'({1'b1, b, 1'b0}));
        lim = 0;
        while (tx_busy && lim < 400) begin
            @(negedge clk);
            lim++;
        end
    endtask

    initial begin
        logic [7:0] rb;
        int         lowc;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // R10: reset state with the port disabled
        check(tx_o == 1'b1 && tx_oe == 1'b0, "R10", "tx released", {tx_oe, tx_o}, 1);
        check(!tx_busy && !rx_valid && !wake_armed && !abd_armed, "R10", "idle flags",
              {tx_busy, rx_valid, wake_armed, abd_armed}, 0);
        check(div_q == 16'd0, "R12", "reset divisor", div_q, 0);

        // R10: writes and frames ignored while disabled
        tx_data = 8'h81;
        pulse(tx_wr);
        wait_clk(40);
        check(tx_o && !tx_busy, "R10", "tx while disabled", {tx_busy, tx_o}, 1);
        rx_send(8'h5A, 1, 1'b1);
        wait_clk(4);
        check(!rx_valid, "R10", "rx while disabled", rx_valid, 0);

        port_en = 1'b1;
        wait_clk(4);
        check(tx_oe == 1'b1, "R10", "output enable", tx_oe, 1);

        // R1 R2 R3: every byte out while another byte comes in
        for (int b = 0; b < 256; b++) begin
            rb = 8'(b) ^ 8'h3C;
            fork
                tx_expect(8'(b), 1, "R1/R3");
                rx_send(rb, 1, 1'b1);
            join
            wait_clk(2);
            check(rx_valid && rx_data == rb && !ferr, "R2/R3", "rx byte",
                  {ferr, rx_valid, rx_data}, {2'b01, rb});
            pulse(rx_rd);
            wait_clk(1);
            check(!rx_valid, "R2", "read clears", rx_valid, 0);
        end

        // R4: break of 12 low bit times plus one stop bit
        tx_brk = 1'b1;
        pulse(tx_wr);
        tx_brk = 1'b0;
        lowc = 0;
        while (tx_o && lowc < 100) begin @(negedge clk); lowc++; end
        lowc = 0;
        while (!tx_o && lowc < 1000) begin @(negedge clk); lowc++; end
        check(lowc == 192, "R4", "break low clocks", lowc, 192);
        wait_clk(8);
        check(tx_o && tx_busy, "R4", "break stop bit", {tx_busy, tx_o}, 3);
        wait_clk(16);
        check(!tx_busy, "R4", "break done", tx_busy, 0);
        tx_expect(8'hE1, 1, "R4");

        // R5: framing error
        rx_send(8'hC3, 1, 1'b0);
        wait_clk(4);
        check(rx_valid && rx_data == 8'hC3 && ferr, "R5", "low stop",
              {ferr, rx_valid, rx_data}, {2'b11, 8'hC3});
        pulse(rx_rd);
        wait_clk(20);
        rx_send(8'h3D, 1, 1'b1);
        wait_clk(2);
        check(rx_valid && rx_data == 8'h3D && !ferr, "R5", "good stop",
              {ferr, rx_valid, rx_data}, {2'b01, 8'h3D});
        pulse(rx_rd);

        // R6: overrun
        rx_send(8'h11, 1, 1'b1);
        rx_send(8'h22, 1, 1'b1);
        wait_clk(2);
        check(oerr && rx_valid && rx_data == 8'h11, "R6", "overrun",
              {oerr, rx_valid, rx_data}, {2'b11, 8'h11});
        port_en = 1'b0;
        wait_clk(1);
        port_en = 1'b1;
        wait_clk(1);
        check(!oerr && !rx_valid, "R10", "disable clears flags", {oerr, rx_valid}, 0);

        // R11: short glitch rejected
        rx_i = 1'b0;
        wait_clk(4);
        rx_i = 1'b1;
        wait_clk(200);
        check(!rx_valid, "R11", "glitch", rx_valid, 0);
        rx_send(8'hA7, 1, 1'b1);
        wait_clk(2);
        check(rx_valid && rx_data == 8'hA7, "R11", "after glitch", {rx_valid, rx_data}, {1'b1, 8'hA7});
        pulse(rx_rd);

        // R7: wake on break
        pulse(wake_arm);
        wait_clk(1);
        check(wake_armed && !wake_flag, "R7", "armed", {wake_armed, wake_flag}, 2);
        rx_i = 1'b0;
        wait_clk(13 * 16);
        check(wake_armed && wake_flag, "R7", "break seen", {wake_armed, wake_flag}, 3);
        rx_i = 1'b1;
        wait_clk(6);
        check(!wake_armed && wake_flag && !rx_valid, "R7", "wake end",
              {wake_armed, wake_flag, rx_valid}, 2);

        // R8: calibration at two bit rates
        for (int k = 0; k < 2; k++) begin
            int p = (k == 0) ? 3 : 5;
            pulse(abd_arm);
            wait_clk(2);
            rx_send(8'h55, p, 1'b1);
            wait_clk(4);
            check(div_q == 16'(p - 1) && !abd_armed && !rx_valid && !abd_ovf, "R8", "calibrated divisor",
                  {abd_ovf, rx_valid, abd_armed, div_q}, p - 1);
            rx_send(8'h96 + 8'(k), p, 1'b1);
            wait_clk(2);
            check(rx_valid && rx_data == 8'h96 + 8'(k), "R8", "rx at new rate",
                  {rx_valid, rx_data}, {1'b1, 8'h96 + 8'(k)});
            pulse(rx_rd);
        end

        // R12: software divisor write
        div_wdata = 16'd7;
        pulse(div_wr);
        check(div_q == 16'd7, "R12", "divisor write", div_q, 7);

        // R9: overflow while the line stays low
        pulse(abd_arm);
        wait_clk(2);
        rx_i = 1'b0;
        wait_clk(65600);
        check(abd_ovf && !abd_armed && div_q == 16'd7, "R9", "overflow",
              {abd_ovf, abd_armed, div_q}, {2'b10, 16'd7});
        rx_i = 1'b1;
        wait_clk(50);
        check(!rx_valid, "R9", "no byte", rx_valid, 0);

        // R12: both directions follow the written divisor
        fork
            tx_expect(8'h4B, 8, "R12");
            rx_send(8'hD2, 8, 1'b1);
        join
        wait_clk(2);
        check(rx_valid && rx_data == 8'hD2, "R12", "rx at written rate", {rx_valid, rx_data}, {1'b1, 8'hD2});

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule